// File: doc/BRIEF.md
# Single-Wire Bus Slave Acknowledge Controller

This block is the slave-side framing engine for a single-wire, Manchester-coded serial memory bus. A front-end decoder hands it one strobe per bit period, together with the decoded bit value, a flag for a period with no mid-bit edge, and a flag for a period in which the line stayed idle. The controller groups bits into bytes (most significant bit first). It follows a frame through the start header, the device address, the command and any later bytes. After each byte it reads the master acknowledge bit and then decides whether to drive a slave acknowledge.

A slave not-acknowledge is never driven. The controller simply leaves the line undriven for that slot. It then drops to a standby state and waits for a run of idle bit periods before it will look at a new start header. Toward the memory back end it gives one-cycle pulses: continue, normal end, abort and write-cycle start. It also hands over every data byte.

Top module: `sw_ack_ctrl`

## Requirements
- R1: After reset, and after any withheld acknowledge, the controller ignores all traffic until it has seen STBY_BITS consecutive idle bit periods (default 8). Any non-idle period restarts that count. Out of reset every output is 0.
- R2: The first byte of a frame must equal HDR_CODE (default 0x55) and must be followed by a master acknowledge of 1. The slave never acknowledges this byte. Any other header byte, or a header followed by 0, returns the controller to standby. While it waits for a header, idle periods are skipped.
- R3: A device address byte equal to DEV_ADDR (default 0xA0: family 1010 in bits 7:4, device 0000 in bits 3:0) gets a slave acknowledge. Any other value gets none and leads to standby.
- R4: A master acknowledge of 0 right after a matching device address still gets a slave acknowledge. The controller then waits for a new header without needing standby. No back-end pulse is raised.
- R5: A command byte outside the recognised set gets no slave acknowledge and raises abort. The recognised set is read 0x03, current-read 0x06, write 0x6C, write-enable 0x96, write-disable 0x91, status-read 0x05, status-write 0x6E, erase-all 0x6D and set-all 0x67.
- R6: When wr_busy_i is 1 at the command's master-acknowledge bit, the commands read, current-read, write, status-write, set-all and erase-all get no acknowledge and raise abort. Write-enable, write-disable and status-read are still accepted.
- R7: The commands write-enable, write-disable, set-all and erase-all are complete in one byte. A master acknowledge of 0 after them gets a slave acknowledge and a done pulse, and for set-all and erase-all also a wr_start pulse. A master acknowledge of 1 after them gets no acknowledge and raises abort.
- R8: A frame is ended too early when the master sends 0 after one of the other commands, or after fewer than ADR_BYTES (default 2) bytes following a read or write. An early end gets no acknowledge and raises abort.
- R9: A write or status-write ended by a master 0 after at least one byte beyond its address bytes gets an acknowledge, done and wr_start. If no such byte was sent, it gets an acknowledge and done but no wr_start.
- R10: A bit period flagged as a sync error (rx_err_i), or an idle period inside a frame, leaves the slave acknowledge undriven and sends the controller to standby. If a command was already accepted or being received, abort is raised.
- R11: sak_o rises in the cycle after the master-acknowledge strobe and falls in the cycle after the next strobe, which is the slave's own slot.
- R12: Every byte that follows an accepted command is presented on byte_o with a one-cycle byte_vld_o in the cycle after its eighth bit strobe.
- R13: A master acknowledge of 1 after an accepted multi-byte command, or after any later byte, gets a slave acknowledge and a one-cycle cont_o. At most one of cont_o, done_o and abort_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb_i | input | 1 | One-cycle strobe at the end of each bit period |
| rx_bit_i | input | 1 | Decoded bit value (rising mid-edge = 1) |
| rx_err_i | input | 1 | Bit period had no valid mid-bit edge |
| rx_idle_i | input | 1 | Line stayed idle for the whole bit period |
| wr_busy_i | input | 1 | Internal write cycle in progress |
| sak_o | output | 1 | Drive a slave acknowledge during the current slot |
| cont_o | output | 1 | Pulse: operation continues |
| done_o | output | 1 | Pulse: operation ended normally |
| abort_o | output | 1 | Pulse: operation abandoned |
| wr_start_o | output | 1 | Pulse: begin the internal write cycle |
| byte_vld_o | output | 1 | Pulse: byte_o holds a new post-command byte |
| byte_o | output | 8 | Last assembled post-command byte |

## Verification
A wrong frame stage or a wrong bit count shows up at the very next master-acknowledge slot. The symptom is an acknowledge driven or withheld the wrong way, or a back-end pulse that should not be there. So a misaligned count is visible within ten bit periods. A wrong saved command or byte count stays hidden until the frame ends, where it shows as a missing or extra wr_start or abort. A standby counter that is off by one only shows when a header is sent right after a shortened idle run. For that reason the bench mixes random frames with short and exact standby runs, busy commands and early terminations at every byte position.

// File: rtl/sw_ack_ctrl.sv
module sw_ack_ctrl #(
  parameter int          STBY_BITS = 8,
  parameter int          ADR_BYTES = 2,
  parameter logic [7:0]  HDR_CODE  = 8'h55,
  parameter logic [7:0]  DEV_ADDR  = 8'hA0,
  parameter logic [7:0]  OP_RD     = 8'h03,
  parameter logic [7:0]  OP_CRD    = 8'h06,
  parameter logic [7:0]  OP_WR     = 8'h6C,
  parameter logic [7:0]  OP_WEN    = 8'h96,
  parameter logic [7:0]  OP_WDI    = 8'h91,
  parameter logic [7:0]  OP_RSR    = 8'h05,
  parameter logic [7:0]  OP_WSR    = 8'h6E,
  parameter logic [7:0]  OP_ERA    = 8'h6D,
  parameter logic [7:0]  OP_SET    = 8'h67
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb_i,
  input  logic       rx_bit_i,
  input  logic       rx_err_i,
  input  logic       rx_idle_i,
  input  logic       wr_busy_i,
  output logic       sak_o,
  output logic       cont_o,
  output logic       done_o,
  output logic       abort_o,
  output logic       wr_start_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o
);
  localparam int SW     = $clog2(STBY_BITS + 1);
  localparam int NBW    = $clog2(ADR_BYTES + 2);
  localparam int NB_MAX = ADR_BYTES + 1;

  typedef enum logic [2:0] {S_STBY, S_HDR, S_DEV, S_CMD, S_DATA} st_t;

  st_t            st, nxt;
  logic [3:0]     cnt;
  logic [7:0]     sh, cmd_q;
  logic [NBW-1:0] nb, nbn, need;
  logic [SW-1:0]  sc;
  logic           ack, go_c, go_d, go_a, go_w;

  wire [7:0] op      = (st == S_CMD) ? sh : cmd_q;
  wire       bad     = rx_err_i | rx_idle_i;
  wire       is_wt   = (op == OP_WR) || (op == OP_WSR);
  wire       is_one  = (op == OP_WEN) || (op == OP_WDI) || (op == OP_SET) || (op == OP_ERA);
  wire       blocked = (op == OP_RD) || (op == OP_CRD) || is_wt || (op == OP_SET) || (op == OP_ERA);
  wire       valid   = blocked || (op == OP_WEN) || (op == OP_WDI) || (op == OP_RSR);

  assign need = ((op == OP_RD) || (op == OP_WR)) ? NBW'(ADR_BYTES) : '0;
  assign nbn  = (nb == NBW'(NB_MAX)) ? nb : nb + 1'b1;

  always_comb begin
    ack = 1'b0; go_c = 1'b0; go_d = 1'b0; go_a = 1'b0; go_w = 1'b0;
    nxt = st;
    case (st)
      S_HDR: nxt = (sh == HDR_CODE && rx_bit_i) ? S_DEV : S_STBY;
      S_DEV:
        if (sh != DEV_ADDR) nxt = S_STBY;
        else begin
          ack = 1'b1;
          nxt = rx_bit_i ? S_CMD : S_HDR;
        end
      S_CMD:
        if (!valid || (wr_busy_i && blocked) || (is_one == rx_bit_i)) begin
          go_a = 1'b1;
          nxt  = S_STBY;
        end else begin
          ack  = 1'b1;
          go_c = rx_bit_i;
          go_d = !rx_bit_i;
          go_w = !rx_bit_i && ((op == OP_SET) || (op == OP_ERA));
          nxt  = rx_bit_i ? S_DATA : S_HDR;
        end
      S_DATA:
        if (rx_bit_i) begin
          ack  = 1'b1;
          go_c = 1'b1;
        end else if (nbn < need) begin
          go_a = 1'b1;
          nxt  = S_STBY;
        end else begin
          ack  = 1'b1;
          go_d = 1'b1;
          go_w = is_wt && (nbn > need);
          nxt  = S_HDR;
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_STBY; cnt <= '0; sh <= '0; cmd_q <= '0; nb <= '0; sc <= '0;
      sak_o <= 1'b0; cont_o <= 1'b0; done_o <= 1'b0; abort_o <= 1'b0;
      wr_start_o <= 1'b0; byte_vld_o <= 1'b0; byte_o <= '0;
    end else begin
      cont_o <= 1'b0; done_o <= 1'b0; abort_o <= 1'b0;
      wr_start_o <= 1'b0; byte_vld_o <= 1'b0;
      if (bit_stb_i) begin
        sak_o <= 1'b0;
        if (st == S_STBY) begin
          cnt <= '0;
          if (!rx_idle_i) sc <= '0;
          else if (sc == SW'(STBY_BITS - 1)) begin
            sc <= '0;
            st <= S_HDR;
          end else sc <= sc + 1'b1;
        end else if (cnt == 4'd9) begin
          cnt <= '0;
        end else if (st == S_HDR && cnt == 4'd0 && rx_idle_i) begin
          cnt <= '0;
        end else if (bad) begin
          st      <= S_STBY;
          cnt     <= '0;
          sc      <= '0;
          abort_o <= (st == S_CMD) || (st == S_DATA);
        end else if (cnt == 4'd8) begin
          cnt        <= 4'd9;
          st         <= nxt;
          sak_o      <= ack;
          cont_o     <= go_c;
          done_o     <= go_d;
          abort_o    <= go_a;
          wr_start_o <= go_w;
          if (st == S_CMD) begin
            cmd_q <= sh;
            nb    <= '0;
          end
          if (st == S_DATA) nb <= nbn;
        end else begin
          sh  <= {sh[6:0], rx_bit_i};
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7 && st == S_DATA) begin
            byte_vld_o <= 1'b1;
            byte_o     <= {sh[6:0], rx_bit_i};
          end
        end
      end
    end
  end
endmodule

// File: rtl/sw_ack_ctrl_chk.sv
module sw_ack_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_stb_i,
  input logic sak_o,
  input logic cont_o,
  input logic done_o,
  input logic abort_o,
  input logic wr_start_o,
  input logic byte_vld_o
);
  AST_PULSE_ONEHOT:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0({cont_o, done_o, abort_o})); // R13
  AST_CONT_HAS_SAK:  assert property (@(posedge clk) disable iff (!rst_n) cont_o |-> sak_o); // R13
  AST_DONE_HAS_SAK:  assert property (@(posedge clk) disable iff (!rst_n) done_o |-> sak_o); // R7
  AST_WR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) wr_start_o |-> done_o); // R9
  AST_ABORT_SILENT:  assert property (@(posedge clk) disable iff (!rst_n) abort_o |-> !sak_o); // R10
  AST_SAK_ONE_SLOT:  assert property (@(posedge clk) disable iff (!rst_n) (sak_o && bit_stb_i) |=> !sak_o); // R11
  AST_SAK_FROM_STB:  assert property (@(posedge clk) disable iff (!rst_n) $rose(sak_o) |-> $past(bit_stb_i)); // R11
  AST_BYTE_FROM_STB: assert property (@(posedge clk) disable iff (!rst_n) byte_vld_o |-> $past(bit_stb_i)); // R12
endmodule

bind sw_ack_ctrl sw_ack_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_stb_i(bit_stb_i), .sak_o(sak_o),
  .cont_o(cont_o), .done_o(done_o), .abort_o(abort_o),
  .wr_start_o(wr_start_o), .byte_vld_o(byte_vld_o)
);

// File: tb/test_sw_ack_ctrl.sv
module test_sw_ack_ctrl;
  localparam int STBY = 8;
  localparam int ADRB = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stb = 1'b0, rbit = 1'b0, rerr = 1'b0, ridle = 1'b0, busy = 1'b0;
  logic sak, cont, done, abrt, wrs, bvld;
  logic [7:0] bo;

  sw_ack_ctrl #(.STBY_BITS(STBY), .ADR_BYTES(ADRB)) i_sw_ack_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_stb_i(stb), .rx_bit_i(rbit), .rx_err_i(rerr),
    .rx_idle_i(ridle), .wr_busy_i(busy), .sak_o(sak), .cont_o(cont), .done_o(done),
    .abort_o(abrt), .wr_start_o(wrs), .byte_vld_o(bvld), .byte_o(bo));

  always #2.5 clk = ~clk;

  int errs = 0, checks = 0;
  int mst = 0;
  int mnb = 0;
  logic [7:0] mcmd = '0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(bit b, bit e, bit idl);
    @(negedge clk);
    stb = 1'b1; rbit = b; rerr = e; ridle = idl;
    @(negedge clk);
    stb = 1'b0; rerr = 1'b0; ridle = 1'b0;
  endtask

  function automatic bit f_blk(logic [7:0] o);
    return o inside {8'h03, 8'h06, 8'h6C, 8'h6E, 8'h67, 8'h6D};
  endfunction
  function automatic bit f_valid(logic [7:0] o);
    return f_blk(o) || (o inside {8'h96, 8'h91, 8'h05});
  endfunction
  function automatic bit f_one(logic [7:0] o);
    return o inside {8'h96, 8'h91, 8'h67, 8'h6D};
  endfunction
  function automatic int f_need(logic [7:0] o);
    return (o == 8'h03 || o == 8'h6C) ? ADRB : 0;
  endfunction

  // e = {sak, cont, done, abort, wr}; states 0 stby, 1 hdr, 2 dev, 3 cmd, 4 data
  function automatic void model(input int st, input logic [7:0] v, input bit mak,
                                output logic [4:0] e, output int nst, output string tag);
    e = 5'b0; nst = st; tag = "R1";
    case (st)
      1: begin tag = "R2"; nst = (v == 8'h55 && mak) ? 2 : 0; end
      2: begin
        tag = mak ? "R3" : "R4";
        if (v != 8'hA0) nst = 0;
        else begin e = 5'b10000; nst = mak ? 3 : 1; end
      end
      3: begin
        if (!f_valid(v)) begin tag = "R5"; e = 5'b00010; nst = 0; end
        else if (busy && f_blk(v)) begin tag = "R6"; e = 5'b00010; nst = 0; end
        else if (f_one(v)) begin
          tag = "R7";
          if (mak) begin e = 5'b00010; nst = 0; end
          else begin e = {3'b101, 1'b0, (v == 8'h67 || v == 8'h6D)}; nst = 1; end
        end else begin
          tag = mak ? "R13" : "R8";
          if (mak) begin e = 5'b11000; nst = 4; end
          else begin e = 5'b00010; nst = 0; end
        end
      end
      4: begin
        if (mak) begin tag = "R13"; e = 5'b11000; end
        else if (mnb + 1 < f_need(mcmd)) begin tag = "R8"; e = 5'b00010; nst = 0; end
        else begin
          tag = "R9";
          e = {4'b1010, ((mcmd == 8'h6C || mcmd == 8'h6E) && (mnb + 1 > f_need(mcmd)))};
          nst = 1;
        end
      end
      default: ;
    endcase
  endfunction

  task automatic xfer(logic [7:0] v, bit mak);
    logic [4:0] e; int nst; string tag;
    for (int i = 7; i >= 0; i--) strobe(v[i], 1'b0, 1'b0);
    if (mst == 4) chk(bvld && bo == v, "R12", {bvld, bo}, {1'b1, v});
    else chk(!bvld, "R12", bvld, 0);
    model(mst, v, mak, e, nst, tag);
    strobe(mak, 1'b0, 1'b0);
    chk({sak, cont, done, abrt, wrs} == e, tag, {sak, cont, done, abrt, wrs}, e);
    strobe(1'b1, 1'b0, !e[4]);
    chk(!sak, "R11", sak, 0);
    if (mst == 3) begin mcmd = v; mnb = 0; end
    else if (mst == 4) mnb++;
    mst = nst;
  endtask

  task automatic standby(int n);
    for (int i = 0; i < n; i++) strobe(1'b1, 1'b0, 1'b1);
    if (n >= STBY && mst <= 1) mst = 1;
  endtask

  task automatic open_frame();
    standby(STBY);
    xfer(8'h55, 1'b1);
    xfer(8'hA0, 1'b1);
  endtask

  initial begin
    #(5ns * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] ops[9];
    ops = '{8'h03, 8'h06, 8'h6C, 8'h96, 8'h91, 8'h05, 8'h6E, 8'h6D, 8'h67};
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    chk({sak, cont, done, abrt, wrs, bvld} == 6'b0, "R1", {sak, cont, done, abrt, wrs, bvld}, 0);
    rst_n = 1'b1;
    // R1: no standby yet, then a short idle run broken by a bit
    xfer(8'h55, 1'b1);
    xfer(8'hA0, 1'b1);
    standby(STBY - 1);
    strobe(1'b0, 1'b0, 1'b0);
    xfer(8'h55, 1'b1);
    xfer(8'hA0, 1'b1);
    // R2: bad header, then header acknowledged with 0
    standby(STBY); xfer(8'h54, 1'b1); xfer(8'hA0, 1'b1);
    standby(STBY); xfer(8'h55, 1'b0); xfer(8'hA0, 1'b1);
    // R3: address mismatch, R4: master 0 after address then direct header
    standby(STBY); xfer(8'h55, 1'b1); xfer(8'hA1, 1'b1);
    standby(STBY); xfer(8'h55, 1'b1); xfer(8'hA0, 1'b0);
    xfer(8'h55, 1'b1); xfer(8'hA0, 1'b1); xfer(8'h96, 1'b0);
    // R5 invalid command
    open_frame(); xfer(8'h00, 1'b1);
    // R6 busy blocks write, allows status read
    busy = 1'b1;
    open_frame(); xfer(8'h6C, 1'b1);
    open_frame(); xfer(8'h05, 1'b1); xfer(8'h3C, 1'b0);
    busy = 1'b0;
    // R7 set-all ends with 0, erase-all continued wrongly
    open_frame(); xfer(8'h67, 1'b0);
    open_frame(); xfer(8'h6D, 1'b1);
    // R8 write stopped inside the address
    open_frame(); xfer(8'h6C, 1'b1); xfer(8'h01, 1'b0);
    // R9 write with address only, then status-write with one byte
    open_frame(); xfer(8'h6C, 1'b1); xfer(8'h00, 1'b1); xfer(8'h10, 1'b0);
    open_frame(); xfer(8'h6E, 1'b1); xfer(8'h8C, 1'b0);
    open_frame(); xfer(8'h6C, 1'b1); xfer(8'h00, 1'b1); xfer(8'h10, 1'b1); xfer(8'hE7, 1'b0);
    // R10 sync error mid-byte inside data
    open_frame(); xfer(8'h03, 1'b1);
    strobe(1'b1, 1'b0, 1'b0); strobe(1'b0, 1'b0, 1'b0);
    strobe(1'b0, 1'b1, 1'b0);
    chk(abrt && !sak, "R10", {abrt, sak}, 2'b10);
    mst = 0;
    xfer(8'h55, 1'b1);
    // random frames
    for (int f = 0; f < 300; f++) begin
      logic [7:0] v; int len;
      if (mst == 0 || $urandom % 4 == 0) standby(STBY);
      busy = ($urandom % 4 == 0);
      v = ($urandom % 10 == 0) ? 8'($urandom) : 8'h55;
      xfer(v, ($urandom % 10) != 0);
      if (mst != 2) continue;
      v = ($urandom % 8 == 0) ? 8'($urandom) : 8'hA0;
      xfer(v, ($urandom % 8) != 0);
      if (mst != 3) continue;
      begin
        int k; k = $urandom % 11;
        v = (k < 9) ? ops[k] : 8'($urandom);
      end
      xfer(v, $urandom % 2);
      len = $urandom % 6;
      for (int k = 0; mst == 4; k++) xfer(8'($urandom), k < len);
    end
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule